// File: doc/BRIEF.md
# SDRAM Refresh Scheduler with Host Arbitration

This block keeps an SDRAM device refreshed while a host issues single read and write accesses through it. A programmable down-counter measures the refresh interval in clock cycles. Each time it expires, a refresh becomes owed. The block lets any access already in flight run to the end of its CAS latency. It then drives a precharge-all, and after the precharge recovery time an auto-refresh. The memory device generates and advances the row to be refreshed itself, so the block drives no refresh row address.

A host raises a request and is held off by a wait signal while a refresh is owed or under way, or while another access occupies the command bus. An accepted access becomes an activate followed, after the activate-to-column delay, by a read or a write. Two things happen if the interval expires again before the owed auto-refresh has gone out. A sticky error bit is set and, unless masked, an interrupt line rises. Reading the status register clears the bit. Three small registers sit behind a simple register port: the interval, the status and the interrupt mask.

Top module: `sdram_refresh_sched`

## Requirements
- R1: With interval N not below T_RP + T_RC + 1 and no host traffic, precharge-all commands appear exactly N cycles apart.
- R2: An interval of zero stops the timer: no refresh command is issued and no error is raised.
- R3: Commands on the active-low pins {cs, ras, cas, we} are: NOP = 0111, activate = 0011, read = 0101, write = 0100, precharge-all = 0010 with sd_a10 high, auto-refresh = 0001. sd_a10 is low for every other command, and the reset state is NOP.
- R4: An auto-refresh follows its precharge-all by exactly T_RP cycles (3). The next command after an auto-refresh comes no sooner than T_RC cycles (8) later, and exactly T_RC later when work is waiting.
- R5: An accepted host access drives an activate, then a read (host_we low) or a write (host_we high) exactly T_RCD cycles (3) later. The access occupies the bus for CAS_LAT cycles (2) after that column command.
- R6: host_wait is high whenever host_req is high and the request is not accepted in that cycle, including while a refresh is owed or its sequence is running. It is low in the cycle a request is accepted.
- R7: A precharge-all never comes sooner than CAS_LAT cycles after the preceding read or write. When a refresh is owed during an access, it comes exactly CAS_LAT cycles after the column command.
- R8: When an owed refresh and a host request compete for a free bus, the precharge-all goes out and the host keeps waiting.
- R9: If the interval expires while an earlier owed auto-refresh has still not been issued, status bit 0 (register address 1) is set.
- R10: A read strobe at the status address (1) clears status bit 0 from the next cycle on; a new error in the same cycle wins over the clear.
- R11: irq equals status bit 0 ANDed with mask bit 0 (register address 2). Changing the mask never alters the status bit.
- R12: Writing the interval register (address 0) with N restarts the timer; the first precharge-all follows N + 1 cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (clears status when at address 1) |
| reg_addr | input | 2 | Register address: 0 interval, 1 status, 2 mask |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data for reg_addr |
| host_req | input | 1 | Host access request, held until accepted |
| host_we | input | 1 | Access direction: 1 write, 0 read |
| host_wait | output | 1 | Host held off this cycle |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_a10 | output | 1 | Address bit 10, high to precharge all banks |
| irq | output | 1 | Missed-refresh interrupt, gated by the mask |

## Verification
The bench builds the block with CNT_W = 8 and the default timings T_RP = 3, T_RC = 8, T_RCD = 3 and CAS_LAT = 2. Intervals of 4 and 5 cycles are shorter than one precharge-plus-refresh sequence, so a missed refresh appears within about fifteen cycles. An owed refresh can also be made to land during a host access, in the same cycle as a competing request. An interval of 20 shows the clean periodic case, and zero shows the disabled timer.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT_GAP,
    ST_CAS_GAP,
    ST_PRE_GAP,
    ST_REF_GAP
  } seq_state_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP = 5'b01110;
  localparam sd_cmd_t CMD_ACT = 5'b00110;
  localparam sd_cmd_t CMD_RD  = 5'b01010;
  localparam sd_cmd_t CMD_WR  = 5'b01000;
  localparam sd_cmd_t CMD_PRE = 5'b00101;
  localparam sd_cmd_t CMD_REF = 5'b00010;

  localparam logic [1:0] ADDR_IVL  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_MASK = 2'd2;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/srs_timer.sv
module srs_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] ivl_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             tick_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = (load_val_i == '0) ? '0 : (load_val_i - ONE);
    end else if (ivl_i == '0) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q == '0) begin
      cnt_d = ivl_i - ONE;
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = (ivl_i != '0) && (cnt_q == '0) && !load_i;

endmodule

// File: rtl/srs_regs.sv
module srs_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             err_set_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic [CNT_W-1:0] ivl_o,
  output logic             ivl_load_o,
  output logic             irq_o
);
  import srs_pkg::*;

  logic [CNT_W-1:0] ivl_q;
  logic             mask_q, mask_en;
  logic             err_q, err_d, stat_rd;

  assign ivl_load_o = wr_en_i && (addr_i == ADDR_IVL);
  assign mask_en    = wr_en_i && (addr_i == ADDR_MASK);
  assign stat_rd    = rd_en_i && (addr_i == ADDR_STAT);

  always_comb begin
    err_d = err_q;
    if (stat_rd)   err_d = 1'b0;
    if (err_set_i) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q <= '0;
    end else if (ivl_load_o) begin
      ivl_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
    end else if (mask_en) begin
      mask_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_IVL:  rdata_o = ivl_q;
      ADDR_STAT: rdata_o = CNT_W'(err_q);
      ADDR_MASK: rdata_o = CNT_W'(mask_q);
      default:   rdata_o = '0;
    endcase
  end

  assign ivl_o = ivl_q;
  assign irq_o = err_q & mask_q;

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_set_i |=> err_q);

  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !err_set_i) |=> !err_q);

  // R11
  mask_keeps_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_en && !stat_rd && !err_set_i) |=> (err_q == $past(err_q)));

endmodule

// File: rtl/srs_seq.sv
module srs_seq #(
  parameter int T_RP    = 3,
  parameter int T_RC    = 8,
  parameter int T_RCD   = 3,
  parameter int CAS_LAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            host_req_i,
  input  logic            host_we_i,
  output logic            grant_o,
  output logic            pend_o,
  output logic            ref_go_o,
  output srs_pkg::sd_cmd_t cmd_o
);
  import srs_pkg::*;

  localparam int MAXT  = max2(max2(T_RP, T_RC), max2(T_RCD, CAS_LAT));
  localparam int GAP_W = $clog2(MAXT) + 1;
  localparam logic [GAP_W-1:0] RP_LD  = GAP_W'(T_RP - 1);
  localparam logic [GAP_W-1:0] RC_LD  = GAP_W'(T_RC - 1);
  localparam logic [GAP_W-1:0] RCD_LD = GAP_W'(T_RCD - 1);
  localparam logic [GAP_W-1:0] CAS_LD = GAP_W'(CAS_LAT - 1);

  seq_state_t       state_q, state_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  sd_cmd_t          cmd_q, cmd_d;
  logic             we_q, pend_q, pend_d, free;

  assign free = (state_q == ST_IDLE) ||
                (((state_q == ST_CAS_GAP) || (state_q == ST_REF_GAP)) && (gap_q == '0));

  always_comb begin
    state_d  = state_q;
    gap_d    = gap_q;
    cmd_d    = CMD_NOP;
    grant_o  = 1'b0;
    ref_go_o = 1'b0;
    case (state_q)
      ST_ACT_GAP: begin
        if (gap_q == '0) begin
          cmd_d   = we_q ? CMD_WR : CMD_RD;
          state_d = ST_CAS_GAP;
          gap_d   = CAS_LD;
        end else begin
          gap_d = gap_q - 1'b1;
        end
      end
      ST_PRE_GAP: begin
        if (gap_q == '0) begin
          cmd_d    = CMD_REF;
          ref_go_o = 1'b1;
          state_d  = ST_REF_GAP;
          gap_d    = RC_LD;
        end else begin
          gap_d = gap_q - 1'b1;
        end
      end
      ST_CAS_GAP, ST_REF_GAP: begin
        if (gap_q == '0) state_d = ST_IDLE;
        else             gap_d   = gap_q - 1'b1;
      end
      default: ;
    endcase
    if (free) begin
      if (pend_q) begin
        cmd_d   = CMD_PRE;
        state_d = ST_PRE_GAP;
        gap_d   = RP_LD;
      end else if (host_req_i) begin
        cmd_d   = CMD_ACT;
        grant_o = 1'b1;
        state_d = ST_ACT_GAP;
        gap_d   = RCD_LD;
      end
    end
  end

  assign pend_d = tick_i | (pend_q & ~ref_go_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gap_q   <= '0;
      cmd_q   <= CMD_NOP;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
      cmd_q   <= cmd_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b0;
    end else if (grant_o) begin
      we_q <= host_we_i;
    end
  end

  assign cmd_o  = cmd_q;
  assign pend_o = pend_q;

  // Cycle ages since each command, saturating; used only by the checks below.
  localparam int AGE_W = GAP_W + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  logic [AGE_W-1:0] act_age, rw_age, pre_age, ref_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_age <= AGE_MAX;
      rw_age  <= AGE_MAX;
      pre_age <= AGE_MAX;
      ref_age <= AGE_MAX;
    end else begin
      act_age <= (cmd_d == CMD_ACT) ? '0 : ((act_age == AGE_MAX) ? act_age : act_age + 1'b1);
      rw_age  <= ((cmd_d == CMD_RD) || (cmd_d == CMD_WR)) ? '0 :
                 ((rw_age == AGE_MAX) ? rw_age : rw_age + 1'b1);
      pre_age <= (cmd_d == CMD_PRE) ? '0 : ((pre_age == AGE_MAX) ? pre_age : pre_age + 1'b1);
      ref_age <= (cmd_d == CMD_REF) ? '0 : ((ref_age == AGE_MAX) ? ref_age : ref_age + 1'b1);
    end
  end

  // R4
  pre_to_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF) |-> (pre_age == AGE_W'(T_RP)));

  // R4
  ref_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q != CMD_NOP) && (cmd_q != CMD_REF)) |-> (ref_age >= AGE_W'(T_RC)));

  // R5
  act_to_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q == CMD_RD) || (cmd_q == CMD_WR)) |-> (act_age == AGE_W'(T_RCD)));

  // R7
  col_to_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |-> (rw_age >= AGE_W'(CAS_LAT)));

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int CNT_W   = 16,
  parameter int T_RP    = 3,
  parameter int T_RC    = 8,
  parameter int T_RCD   = 3,
  parameter int CAS_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_rd_en,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             host_req,
  input  logic             host_we,
  output logic             host_wait,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic             sd_a10,
  output logic             irq
);
  import srs_pkg::*;

  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic [CNT_W-1:0] ivl;
  logic             ivl_load, tick, grant, pend, ref_go, err_set;
  sd_cmd_t          cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  srs_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_ni),
    .wr_en_i   (reg_wr_en),
    .rd_en_i   (reg_rd_en),
    .addr_i    (reg_addr),
    .wdata_i   (reg_wdata),
    .err_set_i (err_set),
    .rdata_o   (reg_rdata),
    .ivl_o     (ivl),
    .ivl_load_o(ivl_load),
    .irq_o     (irq)
  );

  srs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_ni),
    .ivl_i     (ivl),
    .load_i    (ivl_load),
    .load_val_i(reg_wdata),
    .tick_o    (tick)
  );

  srs_seq #(
    .T_RP   (T_RP),
    .T_RC   (T_RC),
    .T_RCD  (T_RCD),
    .CAS_LAT(CAS_LAT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .tick_i    (tick),
    .host_req_i(host_req),
    .host_we_i (host_we),
    .grant_o   (grant),
    .pend_o    (pend),
    .ref_go_o  (ref_go),
    .cmd_o     (cmd)
  );

  assign err_set   = tick & pend & ~ref_go;
  assign host_wait = host_req & ~grant;

  assign sd_cs_n  = cmd.cs_n;
  assign sd_ras_n = cmd.ras_n;
  assign sd_cas_n = cmd.cas_n;
  assign sd_we_n  = cmd.we_n;
  assign sd_a10   = cmd.a10;

  // R6
  wait_while_owed_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (host_req && pend) |-> host_wait);

  // R2
  idle_timer_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((ivl == '0) && !ivl_load) |-> !tick);

  // R8
  refresh_first_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend && host_req) |=> (cmd != CMD_ACT));

endmodule

// File: tb/sdram_refresh_sched_bench.sv
module sdram_refresh_sched_bench;

  localparam int CNT_W = 8;
  localparam int WD_LIMIT = 200000;
  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_REF = 5, C_BAD = 6;

  logic             clk;
  logic             rst_n;
  logic             reg_wr_en, reg_rd_en;
  logic [1:0]       reg_addr;
  logic [CNT_W-1:0] reg_wdata, reg_rdata;
  logic             host_req, host_we, host_wait;
  logic             sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10, irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  sdram_refresh_sched #(.CNT_W(CNT_W)) u_sdram_refresh_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .host_req (host_req),
    .host_we  (host_we),
    .host_wait(host_wait),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_a10   (sd_a10),
    .irq      (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected under %0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  function automatic int decode();
    case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10})
      5'b01110: return C_NOP;
      5'b00110: return C_ACT;
      5'b01010: return C_RD;
      5'b01000: return C_WR;
      5'b00101: return C_PRE;
      5'b00010: return C_REF;
      default:  return C_BAD;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input int d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = CNT_W'(d);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_cmd(input int target, input int limit, output int k);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (decode() == target) begin
        k = i;
        return;
      end
    end
    k = -1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; reg_wr_en = 0; reg_rd_en = 0; reg_addr = 2'd0; reg_wdata = '0;
    host_req = 0; host_we = 0;
    repeat (3) @(negedge clk);
    chk(decode() == C_NOP, "R3 reset NOP", decode(), C_NOP);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(decode() == C_NOP, "R3 idle NOP", decode(), C_NOP);
    chk(irq == 0, "R11 reset irq", irq, 0);
    chk(host_wait == 0, "R6 no wait idle", host_wait, 0);
    reg_addr = 2'd1; #1;
    chk(reg_rdata[0] == 0, "R9 reset status", reg_rdata[0], 0);
  endtask

  task automatic t_interval();
    int k;
    wr_reg(2'd0, 20);
    wait_cmd(C_PRE, 60, k);
    chk(k == 21, "R12 first refresh delay", k, 21);
    chk(sd_a10 == 1 && sd_ras_n == 0 && sd_we_n == 0 && sd_cas_n == 1,
        "R3 precharge-all pins", {sd_ras_n, sd_cas_n, sd_we_n, sd_a10}, 4'b0101);
    wait_cmd(C_REF, 20, k);
    chk(k == 3, "R4 PRE to REF", k, 3);
    chk(sd_ras_n == 0 && sd_cas_n == 0 && sd_we_n == 1 && sd_a10 == 0,
        "R3 refresh pins", {sd_ras_n, sd_cas_n, sd_we_n, sd_a10}, 4'b0010);
    wait_cmd(C_PRE, 40, k);
    chk(k == 17, "R1 refresh period", k + 3, 20);
    wait_cmd(C_REF, 20, k);
    wr_reg(2'd0, 0);
    reg_addr = 2'd1; #1;
    chk(reg_rdata[0] == 0, "R9 no error at long interval", reg_rdata[0], 0);
  endtask

  task automatic t_disable();
    int seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (decode() != C_NOP) seen++;
    end
    chk(seen == 0, "R2 no commands when disabled", seen, 0);
    reg_addr = 2'd1; #1;
    chk(reg_rdata[0] == 0, "R2 no error when disabled", reg_rdata[0], 0);
  endtask

  task automatic t_host();
    int k;
    @(negedge clk);
    host_req = 1; host_we = 0; #1;
    chk(host_wait == 0, "R6 accepted no wait", host_wait, 1'b0);
    @(negedge clk);
    chk(decode() == C_ACT, "R3 activate pins", decode(), C_ACT);
    host_we = 1; #1;
    chk(host_wait == 1, "R6 wait during access", host_wait, 1);
    wait_cmd(C_RD, 10, k);
    chk(k == 3, "R5 ACT to READ", k, 3);
    wait_cmd(C_ACT, 10, k);
    chk(k == 2, "R5 read occupies CAS latency", k, 2);
    host_req = 0;
    wait_cmd(C_WR, 10, k);
    chk(k == 3, "R5 ACT to WRITE", k, 3);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_arbitrate();
    int k;
    @(negedge clk);
    reg_wr_en = 1; reg_addr = 2'd0; reg_wdata = CNT_W'(4);
    host_req = 1; host_we = 0; #1;
    chk(host_wait == 0, "R6 grant no wait", host_wait, 0);
    @(negedge clk);
    reg_wr_en = 0; host_req = 0;
    chk(decode() == C_ACT, "R5 activate", decode(), C_ACT);
    wait_cmd(C_RD, 10, k);
    chk(k == 3, "R5 ACT to READ", k, 3);
    host_req = 1; #1;
    chk(host_wait == 1, "R6 wait while busy", host_wait, 1);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = 2'd0; reg_wdata = '0;
    chk(decode() == C_NOP, "R7 no PRE inside CAS latency", decode(), C_NOP);
    @(negedge clk);
    reg_wr_en = 0;
    chk(decode() == C_PRE, "R8 refresh wins over host", decode(), C_PRE);
    chk(decode() == C_PRE, "R7 PRE at CAS latency", decode(), C_PRE);
    chk(host_wait == 1, "R6 wait while refresh owed", host_wait, 1);
    wait_cmd(C_REF, 10, k);
    chk(k == 3, "R4 PRE to REF", k, 3);
    @(negedge clk);
    chk(host_wait == 1, "R6 wait during refresh", host_wait, 1);
    wait_cmd(C_ACT, 20, k);
    chk(k == 7, "R4 REF to ACT", k + 1, 8);
    host_req = 0;
    wait_cmd(C_RD, 10, k);
    chk(k == 3, "R5 ACT to READ after refresh", k, 3);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_error();
    wr_reg(2'd2, 0);
    wr_reg(2'd0, 5);
    repeat (25) @(negedge clk);
    wr_reg(2'd0, 0);
    repeat (30) @(negedge clk);
    reg_addr = 2'd1; #1;
    chk(reg_rdata[0] == 1, "R9 missed refresh sets status", reg_rdata[0], 1);
    chk(irq == 0, "R11 masked irq", irq, 0);
    wr_reg(2'd2, 1);
    reg_addr = 2'd1; #1;
    chk(irq == 1, "R11 unmasked irq", irq, 1);
    chk(reg_rdata[0] == 1, "R11 mask keeps status", reg_rdata[0], 1);
    @(negedge clk);
    reg_rd_en = 1; reg_addr = 2'd1;
    @(negedge clk);
    reg_rd_en = 0; #1;
    chk(reg_rdata[0] == 0, "R10 read clears status", reg_rdata[0], 0);
    chk(irq == 0, "R10 irq drops after clear", irq, 0);
  endtask

  initial begin
    t_reset();
    t_interval();
    t_disable();
    t_host();
    t_arbitrate();
    t_error();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule